// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-rank, four-bank, 16-bit SDR SDRAM from power-on to normal operation by driving its command, bank, address, clock-enable and mask pins. After reset it keeps the clock enable high and sends NOPs for a long settling wait. It then closes every bank with one PRECHARGE-ALL, waits the programmed precharge time and runs a dense burst of AUTO-REFRESH commands, one every 16 clocks, for a programmed window. After a 128-clock gap it loads the mode register and waits another 128 clocks. It then raises `init_done` and passes the pins to a normal-operation port driven by the surrounding controller.

Two values depend on static configuration inputs. The mode-register word (burst length 8, sequential, CAS latency 2) reaches the pins through a system address. That address is the word shifted left by the column bits, plus one for the 16-bit bus, plus the bank bits when the address map is row/bank/column. The bank bits are left out of the shift when the map is bank/row/column. Bank-select pins always take system address bits 14:13. The block also supplies a refresh interval, in units of 16 clocks, for an outside refresh timer. It computes this value from the clock frequency, the refresh period and the number of refresh rows.

The state machine runs in this order. `ST_POWERUP` goes to `ST_PRECHARGE` when the power-up wait expires. `ST_PRECHARGE` lasts one cycle and goes to `ST_PRE_WAIT`. `ST_PRE_WAIT` goes to `ST_BURST_REF` after the precharge time. `ST_BURST_REF` goes to `ST_SETTLE` when the refresh window expires. `ST_SETTLE` goes to `ST_LOAD_MODE` after 128 clocks. `ST_LOAD_MODE` lasts one cycle and goes to `ST_MODE_WAIT`. `ST_MODE_WAIT` goes to `ST_NORMAL` after 128 clocks. `ST_NORMAL` holds until reset. A single shared down-counter times every state, and the state advances when that counter reaches zero.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted and for POWERUP_CYC cycles after its release, the pins show CKE=1, the NOP command {cs_n,ras_n,cas_n,we_n}=4'b0111, DQM all ones, and init_done=0.
- R2: In the cycle after the power-up wait, exactly one PRECHARGE-ALL (4'b0010) appears, with address bit 10 high, all other address bits 0 and BA=0. It is followed by NOPs for TRP_M1+1 cycles, because the precharge time is programmed as its cycle count minus one.
- R3: Right after the precharge wait, AUTO-REFRESH (4'b0001, address 0, BA 0) is issued once every 16 clocks across a window of BURST_REF_CYC clocks. The first refresh falls in the first cycle of the window, and NOPs fill the cycles between refreshes.
- R4: After the refresh window, NOPs are held for 128 cycles, and then a single LOAD-MODE command (4'b0000) is issued.
- R5: During LOAD-MODE the address pins carry 12'h023. The system address is 0x23 shifted left by col_bits + 1 + (map_brc ? 0 : bank_bits), and BA equals bits 14:13 of that system address.
- R6: After LOAD-MODE, NOPs are held for 128 cycles. init_done then rises in the next cycle and stays high until reset.
- R7: Before init_done, the normal-operation port has no effect on any pin. From the cycle init_done is high, the command, BA, address and DQM pins equal the normal-port inputs in the same cycle, and CKE stays 1.
- R8: refresh_interval equals floor(floor(clk_khz*refresh_ms / refresh_rows) / 16) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_clk_khz | input | 20 | Clock frequency in kHz |
| cfg_refresh_ms | input | 8 | Refresh period in ms |
| cfg_refresh_rows | input | 16 | Refresh commands per period |
| cfg_col_bits | input | 4 | Column address bits of the device |
| cfg_bank_bits | input | 2 | Bank address bits of the device |
| cfg_map_brc | input | 1 | 1 = bank/row/column map, 0 = row/bank/column map |
| nrm_cmd | input | 4 | Normal-port command {cs_n,ras_n,cas_n,we_n} |
| nrm_ba | input | 2 | Normal-port bank select |
| nrm_addr | input | 12 | Normal-port address |
| nrm_dqm | input | 2 | Normal-port byte masks |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Address |
| sd_dqm | output | 2 | Byte masks |
| init_done | output | 1 | Initialization complete |
| refresh_interval | output | 16 | Operating refresh interval in 16-clock units |

## Verification
A wrong state or a wrong count in the shared counter shows up as a command in the wrong cycle. The reference follows every pin cycle by cycle against a precomputed list of events, so a slip of one cycle is reported at the very next non-NOP command or at the first missing one. A wrong address shift shows at the LOAD-MODE cycle as a wrong bank value. The bench runs three maps chosen so that the expected BA differs among them. A hand-off that happens too early shows at once: the normal-port stimulus is deliberately different from every init value.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_PRECHARGE,
        ST_PRE_WAIT,
        ST_BURST_REF,
        ST_SETTLE,
        ST_LOAD_MODE,
        ST_MODE_WAIT,
        ST_NORMAL
    } init_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP       = 4'b0111;
    localparam logic [3:0] CMD_PRECHARGE = 4'b0010;
    localparam logic [3:0] CMD_REFRESH   = 4'b0001;
    localparam logic [3:0] CMD_LOAD_MODE = 4'b0000;

    // burst length 8, sequential, CAS latency 2
    localparam logic [11:0] MODE_WORD = 12'h023;

    localparam int PRE_ALL_BIT = 10;
    localparam int BANK_LSB    = 13;

endpackage

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int CNT_W      = 24,
    parameter int RESET_LOAD = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= CNT_W'(RESET_LOAD);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_mode_addr.sv
module sdram_mode_addr
    import sdram_init_pkg::*;
#(
    parameter int ROW_BITS  = 12,
    parameter int BANK_PINS = 2,
    parameter int BUS_WIDTH = 16
) (
    input  logic [3:0]           col_bits,
    input  logic [1:0]           bank_bits,
    input  logic                 map_brc,
    output logic [ROW_BITS-1:0]  mode_a,
    output logic [BANK_PINS-1:0] mode_ba
);
    localparam int WIDTH_SHIFT = BUS_WIDTH / 16;

    logic [5:0]  shift;
    logic [31:0] sys_addr;
    logic [31:0] row_field;

    always_comb begin
        shift     = 6'(col_bits) + 6'(WIDTH_SHIFT) + (map_brc ? 6'd0 : 6'(bank_bits));
        sys_addr  = 32'(MODE_WORD) << shift;
        row_field = sys_addr >> shift;
        mode_a    = row_field[ROW_BITS-1:0];
        mode_ba   = sys_addr[BANK_LSB +: BANK_PINS];
    end

endmodule

// File: rtl/sdram_refresh_interval.sv
module sdram_refresh_interval #(
    parameter int KHZ_W    = 20,
    parameter int MS_W     = 8,
    parameter int ROWS_W   = 16,
    parameter int IVL_W    = 16,
    parameter int REF_SLOT = 16
) (
    input  logic [KHZ_W-1:0]  clk_khz,
    input  logic [MS_W-1:0]   refresh_ms,
    input  logic [ROWS_W-1:0] refresh_rows,
    output logic [IVL_W-1:0]  interval
);
    localparam int PROD_W  = KHZ_W + MS_W;
    localparam int SLOT_SH = $clog2(REF_SLOT);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rows_nz;
    logic [PROD_W-1:0] per_row;

    always_comb begin
        prod     = PROD_W'(clk_khz) * PROD_W'(refresh_ms);
        rows_nz  = (refresh_rows == '0) ? PROD_W'(1) : PROD_W'(refresh_rows);
        per_row  = prod / rows_nz;
        interval = IVL_W'((per_row >> SLOT_SH) + PROD_W'(1));
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int ROW_BITS      = 12,
    parameter int BANK_PINS     = 2,
    parameter int DQM_PINS      = 2,
    parameter int BUS_WIDTH     = 16,
    parameter int POWERUP_CYC   = 12000000,
    parameter int BURST_REF_CYC = 120000,
    parameter int MODE_GAP_CYC  = 128,
    parameter int TRP_M1        = 0,
    parameter int REF_SLOT      = 16,
    parameter int KHZ_W         = 20,
    parameter int MS_W          = 8,
    parameter int ROWS_W        = 16,
    parameter int IVL_W         = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KHZ_W-1:0]     cfg_clk_khz,
    input  logic [MS_W-1:0]      cfg_refresh_ms,
    input  logic [ROWS_W-1:0]    cfg_refresh_rows,
    input  logic [3:0]           cfg_col_bits,
    input  logic [1:0]           cfg_bank_bits,
    input  logic                 cfg_map_brc,
    input  logic [3:0]           nrm_cmd,
    input  logic [BANK_PINS-1:0] nrm_ba,
    input  logic [ROW_BITS-1:0]  nrm_addr,
    input  logic [DQM_PINS-1:0]  nrm_dqm,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_PINS-1:0] sd_ba,
    output logic [ROW_BITS-1:0]  sd_addr,
    output logic [DQM_PINS-1:0]  sd_dqm,
    output logic                 init_done,
    output logic [IVL_W-1:0]     refresh_interval
);
    localparam int MAX_A   = (POWERUP_CYC > BURST_REF_CYC) ? POWERUP_CYC : BURST_REF_CYC;
    localparam int MAX_B   = (MODE_GAP_CYC > TRP_M1 + 1) ? MODE_GAP_CYC : TRP_M1 + 1;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int PHASE_W = $clog2(REF_SLOT);

    init_state_t          state, state_nx;
    logic                 tmr_expired;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_val;
    logic [PHASE_W-1:0]   phase;
    logic [ROW_BITS-1:0]  mode_a;
    logic [BANK_PINS-1:0] mode_ba;
    logic [3:0]           init_cmd;
    logic [ROW_BITS-1:0]  init_a;
    logic [BANK_PINS-1:0] init_ba;
    logic [3:0]           pin_cmd;

    sdram_wait_timer #(
        .CNT_W      (CNT_W),
        .RESET_LOAD (POWERUP_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_mode_addr #(
        .ROW_BITS  (ROW_BITS),
        .BANK_PINS (BANK_PINS),
        .BUS_WIDTH (BUS_WIDTH)
    ) u_mode_addr (
        .col_bits  (cfg_col_bits),
        .bank_bits (cfg_bank_bits),
        .map_brc   (cfg_map_brc),
        .mode_a    (mode_a),
        .mode_ba   (mode_ba)
    );

    sdram_refresh_interval #(
        .KHZ_W    (KHZ_W),
        .MS_W     (MS_W),
        .ROWS_W   (ROWS_W),
        .IVL_W    (IVL_W),
        .REF_SLOT (REF_SLOT)
    ) u_ivl (
        .clk_khz      (cfg_clk_khz),
        .refresh_ms   (cfg_refresh_ms),
        .refresh_rows (cfg_refresh_rows),
        .interval     (refresh_interval)
    );

    // next state and the duration (minus one) of the state being entered
    always_comb begin
        state_nx = state;
        tmr_val  = '0;
        unique case (state)
            ST_POWERUP:   state_nx = ST_PRECHARGE;
            ST_PRECHARGE: begin state_nx = ST_PRE_WAIT;  tmr_val = CNT_W'(TRP_M1); end
            ST_PRE_WAIT:  begin state_nx = ST_BURST_REF; tmr_val = CNT_W'(BURST_REF_CYC - 1); end
            ST_BURST_REF: begin state_nx = ST_SETTLE;    tmr_val = CNT_W'(MODE_GAP_CYC - 1); end
            ST_SETTLE:    state_nx = ST_LOAD_MODE;
            ST_LOAD_MODE: begin state_nx = ST_MODE_WAIT; tmr_val = CNT_W'(MODE_GAP_CYC - 1); end
            ST_MODE_WAIT: state_nx = ST_NORMAL;
            ST_NORMAL:    state_nx = ST_NORMAL;
        endcase
        tmr_load = tmr_expired && (state != ST_NORMAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_POWERUP;
        else if (tmr_load)
            state <= state_nx;
    end

    // refresh slot counter, held at zero outside the burst window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (state != ST_BURST_REF)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_comb begin
        init_cmd = CMD_NOP;
        init_a   = '0;
        init_ba  = '0;
        unique case (state)
            ST_PRECHARGE: begin
                init_cmd             = CMD_PRECHARGE;
                init_a[PRE_ALL_BIT]  = 1'b1;
            end
            ST_BURST_REF: if (phase == '0) init_cmd = CMD_REFRESH;
            ST_LOAD_MODE: begin
                init_cmd = CMD_LOAD_MODE;
                init_a   = mode_a;
                init_ba  = mode_ba;
            end
            ST_POWERUP, ST_PRE_WAIT, ST_SETTLE, ST_MODE_WAIT, ST_NORMAL: ;
        endcase

        init_done = (state == ST_NORMAL);
        sd_cke    = 1'b1;
        if (init_done) begin
            pin_cmd = nrm_cmd;
            sd_ba   = nrm_ba;
            sd_addr = nrm_addr;
            sd_dqm  = nrm_dqm;
        end else begin
            pin_cmd = init_cmd;
            sd_ba   = init_ba;
            sd_addr = init_a;
            sd_dqm  = '1;
        end
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pin_cmd;
    end

    assert_advance_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expired && state != ST_NORMAL) |=> (state != $past(state)));

    assert_burst_after_precharge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST_REF && $past(state) != ST_BURST_REF) |-> ($past(state) == ST_PRE_WAIT));

    assert_refresh_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && pin_cmd == CMD_REFRESH) |=> (pin_cmd != CMD_REFRESH));

    assert_mode_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD_MODE) |-> (sd_addr == MODE_WORD[ROW_BITS-1:0]));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(state) == ST_MODE_WAIT));

endmodule

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int P_UP   = 40;
    localparam int P_BUR  = 64;
    localparam int P_TRP1 = 2;
    localparam int GAP    = 128;

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [11:0] a;
        logic [1:0]  ba;
        logic [15:0] tag;
    } exp_t;

    exp_t exp_q[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_clk_khz = 20'd60000;
    logic [7:0]  cfg_refresh_ms = 8'd64;
    logic [15:0] cfg_refresh_rows = 16'd4096;
    logic [3:0]  cfg_col_bits = 4'd8;
    logic [1:0]  cfg_bank_bits = 2'd2;
    logic        cfg_map_brc = 1'b0;
    logic [3:0]  nrm_cmd = 4'b0000;
    logic [1:0]  nrm_ba = 2'b11;
    logic [11:0] nrm_addr = 12'h5A5;
    logic [1:0]  nrm_dqm = 2'b01;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic        init_done;
    logic [15:0] refresh_interval;

    int checks = 0;
    int errors = 0;
    int s_done = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_powerup_seq #(
        .POWERUP_CYC   (P_UP),
        .BURST_REF_CYC (P_BUR),
        .TRP_M1        (P_TRP1)
    ) i_sdram_powerup_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_clk_khz      (cfg_clk_khz),
        .cfg_refresh_ms   (cfg_refresh_ms),
        .cfg_refresh_rows (cfg_refresh_rows),
        .cfg_col_bits     (cfg_col_bits),
        .cfg_bank_bits    (cfg_bank_bits),
        .cfg_map_brc      (cfg_map_brc),
        .nrm_cmd          (nrm_cmd),
        .nrm_ba           (nrm_ba),
        .nrm_addr         (nrm_addr),
        .nrm_dqm          (nrm_dqm),
        .sd_cke           (sd_cke),
        .sd_cs_n          (sd_cs_n),
        .sd_ras_n         (sd_ras_n),
        .sd_cas_n         (sd_cas_n),
        .sd_we_n          (sd_we_n),
        .sd_ba            (sd_ba),
        .sd_addr          (sd_addr),
        .sd_dqm           (sd_dqm),
        .init_done        (init_done),
        .refresh_interval (refresh_interval)
    );

    task automatic check(input logic [15:0] tag, input logic [31:0] act,
                         input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [1:0] exp_mode_ba(input int col, input int bank, input bit brc);
        int sh = col + 1 + (brc ? 0 : bank);
        logic [31:0] sys = 32'h23 << sh;
        return sys[14:13];
    endfunction

    // driver: push the expected non-NOP events of one run
    task automatic plan_run(input int col, input int bank, input bit brc);
        int s0 = P_UP + 1 + P_TRP1 + 1;
        int s_lm = s0 + P_BUR + GAP;
        exp_q.delete();
        exp_q.push_back('{P_UP, 4'b0010, 12'h400, 2'b00, "R2"});
        for (int k = 0; k < P_BUR / 16; k++)
            exp_q.push_back('{s0 + 16 * k, 4'b0001, 12'h000, 2'b00, "R3"});
        exp_q.push_back('{s_lm, 4'b0000, 12'h023, exp_mode_ba(col, bank, brc), "R5"});
        s_done = s_lm + 1 + GAP;
    endtask

    // monitor: follow the pins cycle by cycle and pop expected events
    task automatic monitor_run();
        for (int s = 1; s <= s_done + 4; s++) begin
            logic [3:0] cmd;
            @(negedge clk);
            #1;
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (s % 50 == 0) check("R1", 32'(sd_cke), 1, "cke high");
            if (s < s_done) begin
                if (init_done !== 1'b0) check("R6", 32'(init_done), 0, "done early");
                if (sd_dqm !== 2'b11) check("R7", 32'(sd_dqm), 32'h3, "dqm before done");
                if (cmd != 4'b0111) begin
                    if (exp_q.size() == 0) begin
                        check("R4", 32'(cmd), 32'h7, $sformatf("unexpected cmd at %0d", s));
                    end else begin
                        exp_t e = exp_q.pop_front();
                        check(e.tag, 32'(s), 32'(e.cyc), "command cycle");
                        check(e.tag, 32'(cmd), 32'(e.cmd), "command code");
                        check(e.tag, 32'(sd_addr), 32'(e.a), "address");
                        check(e.tag, 32'(sd_ba), 32'(e.ba), "bank");
                    end
                end else if (exp_q.size() != 0 && exp_q[0].cyc <= s) begin
                    check(exp_q[0].tag, 32'(cmd), 32'(exp_q[0].cmd), "missing command");
                    void'(exp_q.pop_front());
                end
            end else begin
                check("R6", 32'(init_done), 1, "done high");
                check("R7", {sd_cke, cmd, sd_ba, sd_addr, sd_dqm},
                      {1'b1, nrm_cmd, nrm_ba, nrm_addr, nrm_dqm}, "normal port pass-through");
            end
        end
        check("R4", 32'(exp_q.size()), 0, "events left over");
    endtask

    task automatic run_case(input int col, input int bank, input bit brc,
                            input int khz, input int ms, input int rows, input int ivl);
        rst_n = 1'b0;
        cfg_col_bits = 4'(col);
        cfg_bank_bits = 2'(bank);
        cfg_map_brc = brc;
        cfg_clk_khz = 20'(khz);
        cfg_refresh_ms = 8'(ms);
        cfg_refresh_rows = 16'(rows);
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1", {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, init_done},
              {1'b1, 4'b0111, 2'b11, 1'b0}, "reset state");
        check("R8", 32'(refresh_interval), 32'(ivl), "refresh interval");
        plan_run(col, bank, brc);
        @(negedge clk);
        rst_n = 1'b1;
        monitor_run();
    endtask

    initial begin
        // R8 expected: ((khz*ms)/rows)/16 + 1
        run_case(8, 2, 1'b0, 60000, 64, 4096, ((60000 * 64) / 4096) / 16 + 1);
        run_case(8, 2, 1'b1, 48000, 64, 8192, ((48000 * 64) / 8192) / 16 + 1);
        run_case(9, 2, 1'b0, 100000, 64, 4096, ((100000 * 64) / 4096) / 16 + 1);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule